// File: doc/BRIEF.md
# Zero-Suppressed Multi-Trigger Event Buffer

This block sits on a 32-channel digitizer and packs the data of successive triggers into one shared word buffer. When a trigger strobe is accepted it stores a header holding the running trigger number. It then stores one word for every channel that saw a hit on that trigger and skips the empty channels. A tail word carrying a fixed marker and the record length closes the record.

Records from many triggers collect in the buffer. The block counts the complete records and the words they occupy. Once the number of buffered records reaches a programmable threshold, it raises an interrupt. The host then reads the block length from the word count and drains the buffer one 32-bit word per read strobe, which suits a block transfer.

While a record is being written, or when fewer than 34 words of space are free, the block reports busy and drops incoming triggers.

Top module: `zs_event_buffer`

## Requirements
- R1: After reset, `busy_o`, `ready_o` and `irq_o` are low, and `word_cnt_o` and `trig_cnt_o` are zero.
- R2: The first word of each record is a header equal to the 32-bit trigger number. The first accepted trigger after reset carries number 0, and each accepted trigger adds one.
- R3: After the header comes one word per hit channel, in ascending channel order, formatted as measured value in bits 31:16 and channel number in bits 15:0. Channels without a hit produce no word.
- R4: The last word of each record holds 16'hE0F1 in bits 31:16 and the record length in words (hits + 2) in bits 15:0.
- R5: A record with n hits is written over n+2 clock cycles, starting at the edge that accepts the trigger. Its words are added to `word_cnt_o` only at the edge that writes its tail.
- R6: `trig_cnt_o` counts complete records still in the buffer. It rises by one when a tail is written and falls by one when a tail is read.
- R7: `irq_o` goes high when a completed record brings `trig_cnt_o` to at least `thresh_i`. It stays high until `word_cnt_o` returns to zero.
- R8: `ready_o` is high exactly when `word_cnt_o` is nonzero.
- R9: `busy_o` is high while a record is being written or while fewer than 34 words are free. A trigger that arrives while `busy_o` is high is ignored and uses up no trigger number.
- R10: A read strobe with `ready_o` high removes one word and lowers `word_cnt_o` by one. A read strobe with `ready_o` low has no effect.
- R11: `rd_data_o` always shows the oldest unread word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger strobe |
| hit_i | input | 32 | Per-channel hit flags |
| val_i | input | 512 | Per-channel 16-bit measured values, channel c at bits 16c+15:16c |
| thresh_i | input | 16 | Record count that raises the interrupt |
| rd_i | input | 1 | Host read strobe, pops one word |
| rd_data_o | output | 32 | Oldest unread word |
| ready_o | output | 1 | Complete records waiting |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Triggers currently ignored |
| word_cnt_o | output | 9 | Words of complete records in the buffer |
| trig_cnt_o | output | 9 | Complete records in the buffer |

## Verification
The assertions assume that `thresh_i` stays constant while records accumulate, since the interrupt-rise check compares the record count against the current threshold. They also assume that a trigger is a single-cycle pulse.

The bench keeps the threshold fixed and drives every trigger for exactly one cycle. It issues read strobes only as explicit drain bursts, or as one deliberate strobe on an empty buffer. The full-buffer case fills the buffer past its limit with all-hit records, so that the dropped trigger and the following trigger numbers can be observed through the read port.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int unsigned VAL_W  = 16;
  localparam int unsigned CH_W   = 16;
  localparam int unsigned WORD_W = VAL_W + CH_W;
  localparam logic [VAL_W-1:0] TAIL_MARK = 16'hE0F1;

  typedef enum logic {ST_IDLE, ST_SCAN} seq_state_e;
endpackage

// File: rtl/zs_hit_pick.sv
module zs_hit_pick #(
  parameter int unsigned NCH   = 32,
  localparam int unsigned IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/zs_fifo.sv
module zs_fifo #(
  parameter int unsigned W     = 33,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] fill_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  assign head_o = mem_q[rd_ptr_q];
  assign fill_o = fill_q;
endmodule

// File: rtl/zs_status.sv
module zs_status #(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned REC_W = 6,
  parameter int unsigned THR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [REC_W-1:0] commit_len_i,
  input  logic             pop_i,
  input  logic             pop_last_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic [CNT_W-1:0] word_cnt_o,
  output logic [CNT_W-1:0] trig_cnt_o,
  output logic             ready_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] word_q, word_d, trig_q, trig_d;
  logic             irq_q;

  always_comb begin
    word_d = word_q;
    trig_d = trig_q;
    if (commit_i) begin
      word_d = word_d + CNT_W'(commit_len_i);
      trig_d = trig_d + 1'b1;
    end
    if (pop_i) begin
      word_d = word_d - 1'b1;
      if (pop_last_i) trig_d = trig_d - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      trig_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      trig_q <= trig_d;
      if (commit_i && (32'(trig_d) >= 32'(thresh_i))) irq_q <= 1'b1;
      else if (word_d == '0)                         irq_q <= 1'b0;
    end
  end

  assign word_cnt_o = word_q;
  assign trig_cnt_o = trig_q;
  assign ready_o    = (word_q != '0);
  assign irq_o      = irq_q;
endmodule

// File: rtl/zs_event_buffer.sv
module zs_event_buffer
  import zs_pkg::*;
#(
  parameter int unsigned NCH   = 32,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned THR_W = 16,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
  localparam int unsigned MAX_REC = NCH + 2,
  localparam int unsigned REC_W   = $clog2(MAX_REC + 1),
  localparam int unsigned IDX_W   = $clog2(NCH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 trig_i,
  input  logic [NCH-1:0]       hit_i,
  input  logic [NCH*VAL_W-1:0] val_i,
  input  logic [THR_W-1:0]     thresh_i,
  input  logic                 rd_i,
  output logic [WORD_W-1:0]    rd_data_o,
  output logic                 ready_o,
  output logic                 irq_o,
  output logic                 busy_o,
  output logic [CNT_W-1:0]     word_cnt_o,
  output logic [CNT_W-1:0]     trig_cnt_o
);
  localparam logic [CNT_W-1:0] ROOM_LIM = CNT_W'(DEPTH - MAX_REC);

  seq_state_e           state_q;
  logic [NCH-1:0]       mask_q;
  logic [NCH*VAL_W-1:0] snap_q;
  logic [WORD_W-1:0]    trig_num_q;
  logic [REC_W-1:0]     rec_len_q;

  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic [CNT_W-1:0]  fill;
  logic [WORD_W:0]   head;
  logic              accept, commit, pop;
  logic              wr_en, wr_last;
  logic [WORD_W-1:0] wr_word;
  logic [REC_W-1:0]  tail_len;

  zs_hit_pick #(.NCH(NCH)) u_pick (
    .mask_i(mask_q),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  assign busy_o   = (state_q != ST_IDLE) || (fill > ROOM_LIM);
  assign accept   = trig_i && !busy_o;
  assign commit   = (state_q == ST_SCAN) && !pick_any;
  assign tail_len = rec_len_q + 1'b1;
  assign pop      = rd_i && ready_o;

  always_comb begin
    wr_en   = 1'b0;
    wr_last = 1'b0;
    wr_word = '0;
    if (accept) begin
      wr_en   = 1'b1;
      wr_word = trig_num_q;
    end else if (state_q == ST_SCAN) begin
      wr_en = 1'b1;
      if (pick_any) begin
        wr_word = {snap_q[pick_idx*VAL_W +: VAL_W], {(CH_W-IDX_W){1'b0}}, pick_idx};
      end else begin
        wr_word = {TAIL_MARK, {(CH_W-REC_W){1'b0}}, tail_len};
        wr_last = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mask_q     <= '0;
      snap_q     <= '0;
      trig_num_q <= '0;
      rec_len_q  <= '0;
    end else if (accept) begin
      state_q    <= ST_SCAN;
      mask_q     <= hit_i;
      snap_q     <= val_i;
      trig_num_q <= trig_num_q + 1'b1;
      rec_len_q  <= REC_W'(1);
    end else if (state_q == ST_SCAN) begin
      if (pick_any) begin
        mask_q[pick_idx] <= 1'b0;
        rec_len_q        <= rec_len_q + 1'b1;
      end else begin
        state_q <= ST_IDLE;
      end
    end
  end

  zs_fifo #(.W(WORD_W + 1), .DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_en),
    .push_data_i({wr_last, wr_word}),
    .pop_i      (pop),
    .head_o     (head),
    .fill_o     (fill)
  );

  assign rd_data_o = head[WORD_W-1:0];

  zs_status #(.CNT_W(CNT_W), .REC_W(REC_W), .THR_W(THR_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .commit_len_i(tail_len),
    .pop_i       (pop),
    .pop_last_i  (head[WORD_W]),
    .thresh_i    (thresh_i),
    .word_cnt_o  (word_cnt_o),
    .trig_cnt_o  (trig_cnt_o),
    .ready_o     (ready_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/zs_event_buffer_chk.sv
module zs_event_buffer_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned THR_W = 16,
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             rd_i,
  input logic             busy_o,
  input logic             ready_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] word_cnt_o,
  input logic [CNT_W-1:0] trig_cnt_o,
  input logic [THR_W-1:0] thresh_i,
  input logic [31:0]      trig_num,
  input logic             accept,
  input logic             commit,
  input logic [CNT_W-1:0] fill
);
  a_r9_busy_drops_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && trig_i) |=> $stable(trig_num));

  a_r2_trig_num_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (trig_num == $past(trig_num) + 32'd1));

  a_r7_irq_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ready_o);

  a_r7_irq_rise_thresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (32'(trig_cnt_o) >= 32'(thresh_i)));

  a_r10_pop_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ready_o && !commit) |=> (word_cnt_o == $past(word_cnt_o) - 1'b1));

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_cnt_o <= fill) && (32'(fill) <= DEPTH));

  a_r8_ready_fall_by_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(rd_i));
endmodule

bind zs_event_buffer zs_event_buffer_chk #(
  .DEPTH(DEPTH), .THR_W(THR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trig_i    (trig_i),
  .rd_i      (rd_i),
  .busy_o    (busy_o),
  .ready_o   (ready_o),
  .irq_o     (irq_o),
  .word_cnt_o(word_cnt_o),
  .trig_cnt_o(trig_cnt_o),
  .thresh_i  (thresh_i),
  .trig_num  (trig_num_q),
  .accept    (accept),
  .commit    (commit),
  .fill      (fill)
);

// File: tb/tb_zs_event_buffer.sv
module tb_zs_event_buffer;
  localparam int NCH   = 32;
  localparam int DEPTH = 256;
  localparam int THR   = 3;
  localparam int MAXR  = NCH + 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            trig_i = 1'b0;
  logic [NCH-1:0]  hit_i = '0;
  logic [NCH*16-1:0] val_i = '0;
  logic [15:0]     thresh_i = 16'(THR);
  logic            rd_i = 1'b0;
  logic [31:0]     rd_data_o;
  logic            ready_o, irq_o, busy_o;
  logic [8:0]      word_cnt_o, trig_cnt_o;

  always #10 clk = ~clk;

  zs_event_buffer #(.NCH(NCH), .DEPTH(DEPTH), .THR_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig_i), .hit_i(hit_i), .val_i(val_i),
    .thresh_i(thresh_i), .rd_i(rd_i), .rd_data_o(rd_data_o), .ready_o(ready_o),
    .irq_o(irq_o), .busy_o(busy_o), .word_cnt_o(word_cnt_o), .trig_cnt_o(trig_cnt_o)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // scoreboard model
  logic [31:0] exp_q[$];
  bit          exp_last_q[$];
  int          exp_words = 0;
  int          exp_recs  = 0;
  bit          exp_irq   = 1'b0;
  int          tnum      = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] val_of(input int t, input int ch);
    return 16'((t * 37 + ch * 101 + 16'h1234) & 16'hFFFF);
  endfunction

  task automatic check_status(input string tag);
    check({tag, " R5 word_cnt"}, 32'(word_cnt_o), 32'(exp_words));
    check({tag, " R6 trig_cnt"}, 32'(trig_cnt_o), 32'(exp_recs));
    check({tag, " R8 ready"}, 32'(ready_o), 32'(exp_words != 0));
    check({tag, " R7 irq"}, 32'(irq_o), 32'(exp_irq));
  endtask

  // driver: fires one trigger and pushes the expected record
  task automatic fire(input logic [NCH-1:0] hits);
    bit accepted;
    int n;
    accepted = (exp_q.size() <= DEPTH - MAXR);
    n = $countones(hits);
    @(negedge clk);
    trig_i = 1'b1;
    hit_i  = hits;
    for (int ch = 0; ch < NCH; ch++) val_i[ch*16 +: 16] = val_of(tnum, ch);
    @(negedge clk);
    trig_i = 1'b0;
    hit_i  = '0;
    if (accepted) begin
      exp_q.push_back(32'(tnum)); exp_last_q.push_back(1'b0);
      for (int ch = 0; ch < NCH; ch++) begin
        if (hits[ch]) begin
          exp_q.push_back({val_of(tnum, ch), 16'(ch)});
          exp_last_q.push_back(1'b0);
        end
      end
      exp_q.push_back({16'hE0F1, 16'(n + 2)}); exp_last_q.push_back(1'b1);
      tnum++;
      // R5: header edge passed, n hit edges and one tail edge remain
      if (n > 0) begin
        repeat (n) @(negedge clk);
        check("R5 not counted before tail", 32'(word_cnt_o), 32'(exp_words));
      end
      @(negedge clk);
      exp_words += n + 2;
      exp_recs++;
      if (exp_recs >= THR) exp_irq = 1'b1;
    end else begin
      repeat (2) @(negedge clk);
    end
  endtask

  // monitor: pops and compares words as the host reads them
  task automatic drain(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      check("R10 ready during read", 32'(ready_o), 32'd1);
      check("R2/R3/R4/R11 read word", rd_data_o, exp_q[0]);
      void'(exp_q.pop_front());
      if (exp_last_q.pop_front()) exp_recs--;
      exp_words--;
      rd_i = 1'b1;
    end
    @(negedge clk);
    rd_i = 1'b0;
    if (exp_words == 0) exp_irq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy_o), 0);
    check("R1 ready", 32'(ready_o), 0);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 word_cnt", 32'(word_cnt_o), 0);
    check("R1 trig_cnt", 32'(trig_cnt_o), 0);

    // R10 read with nothing ready is ignored
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    @(negedge clk);
    check("R10 empty read word_cnt", 32'(word_cnt_o), 0);

    fire(32'h8000_0005);
    check_status("A");
    fire(32'h0000_0000);
    check_status("B");
    fire('1);
    check_status("C");

    drain(5);
    check_status("after first record R7 sticky");
    drain(exp_q.size());
    check_status("drained");

    // R9 full buffer
    for (int r = 0; r < 7; r++) begin
      fire('1);
      if (r == 5) check("R9 room left busy", 32'(busy_o), 0);
    end
    check("R9 busy when full", 32'(busy_o), 1);
    check_status("full");
    fire(32'h0000_00FF);
    check("R9 ignored trigger word_cnt", 32'(word_cnt_o), 32'(exp_words));
    drain(MAXR);
    check("R9 busy released", 32'(busy_o), 0);
    fire(32'h0F0F_0000);
    check_status("refill");
    drain(exp_q.size());
    check_status("drained2");

    // varied hit patterns
    lfsr = 32'hACE1_1234;
    for (int r = 0; r < 5; r++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      fire(lfsr & 32'h5A3C_96E1);
      check_status("pattern");
    end
    drain(exp_q.size());
    check_status("drained3");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule